// File: doc/BRIEF.md
# Symbol Edge Timing Checker

This block watches one receive path and decides whether the incoming symbol edges fall close enough to the positions that an upstream clock recovery circuit predicts. The recovery logic raises a one-cycle strobe at each expected edge position. A separate detector raises a one-cycle strobe whenever it sees a real edge. The checker pairs the two and counts how many symbols in a row arrived on time. It raises a timing-OK flag once that run is long enough, and it pulses an error flag for every symbol that misses.

Two 4-bit codes configure the check. The tolerance code sets a symmetric window of code/32 of the symbol period on each side of the expected position. The window is measured in sample clocks and rounded down. The size code n selects a required run of 2n−1 consecutive good symbols, and a code of zero turns the check off. The path owner sets both codes, together with the symbol period, while the path is disabled. The block copies them while the enable is low and holds those copies for as long as the enable stays high.

Top module: `sym_edge_chk`

## Requirements
- R1: The window half-width is W = (sym_period × tol_code) >> 5 sample clocks. An edge strobe from W cycles before to W cycles after an expected-edge strobe, both ends included, makes that symbol pass. An offset of W+1 on either side fails.
- R2: With tol_code = 0 the window is zero wide. Only an edge strobe in the same cycle as the expected-edge strobe passes, and an offset of one cycle fails.
- R3: With size_code = n (1 to 15), timing_ok rises in the cycle after the (2n−1)-th consecutive passing symbol. It stays low while fewer passes have been seen.
- R4: With size_code = 0 the check is off: timing_ok and timing_err stay low whatever the strobes do.
- R5: Each timing failure sets timing_err high for one cycle, the cycle after the failure is known, and clears timing_ok and the pass run in that same cycle. A timing failure is an edge outside every window, an expected edge with no edge in its window, or a second unclaimed edge.
- R6: tol_code, size_code and sym_period are copied on every clock while en is low and held while en is high. Changes made while enabled have no effect.
- R7: One clock after en goes low, timing_ok and timing_err are low and all matching state and the pass run are cleared. After re-enabling, a full new run is needed.
- R8: While rst_n is low (synchronous reset), timing_ok and timing_err are low and both stored codes are zero.
- R9: Once timing_ok is high, further passing symbols keep it high and the pass run saturates at the required count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Path enable; configuration is copied while low |
| tol_code | input | 4 | Edge tolerance code, window = code/32 of the period |
| size_code | input | 4 | Run length code, 2n−1 symbols; 0 disables the check |
| sym_period | input | PER_W (8) | Symbol period in sample clocks |
| exp_stb | input | 1 | One-cycle strobe at each expected edge position |
| edge_stb | input | 1 | One-cycle strobe at each detected edge |
| timing_ok | output | 1 | Required run of on-time symbols reached |
| timing_err | output | 1 | One-cycle pulse per failed symbol |

## Verification
A wrong window width shows up as a wrong verdict at exactly the W and W+1 offsets. The bench drives both sides of that boundary, and the result reaches timing_err at most W+1 cycles after the strobe in question. A pass counter or stored size that is off by one changes the symbol count at which timing_ok rises, so driving one symbol short of the run and then the full run exposes it within one symbol period. Stale matching state or stale configuration left over from an earlier enable shows up as a spurious error or an early OK on the first symbols after re-enabling.

// File: rtl/sec_pkg.sv
// Shared constants and helpers for the symbol edge timing checker.
// Assumes 4-bit configuration codes and a window resolution of 1/32 period.
package sec_pkg;
    localparam int CODE_W  = 4;   // width of both configuration codes
    localparam int FRAC_SH = 5;   // window step is period >> FRAC_SH

    // Number of consecutive good symbols required for a size code (2n-1, 0 = off).
    function automatic logic [CODE_W:0] need_of(input logic [CODE_W-1:0] sz);
        if (sz == '0) return '0;
        return {sz, 1'b0} - (CODE_W + 1)'(1);
    endfunction
endpackage

// File: rtl/sec_cfg.sv
// Configuration capture: copies the codes and the period while the path is
// disabled and freezes them while enabled. Produces the window half-width in
// sample clocks and the required run length.
// Assumes the codes are static whenever en is high.
module sec_cfg #(
    parameter int PER_W  = 8,
    localparam int CW     = sec_pkg::CODE_W,
    localparam int NEED_W = CW + 1,
    localparam int PROD_W = PER_W + CW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [CW-1:0]     tol_code,
    input  logic [CW-1:0]     size_code,
    input  logic [PER_W-1:0]  sym_period,
    output logic [PER_W-1:0]  win_q,
    output logic [NEED_W-1:0] need_q
);
    logic [PROD_W-1:0] prod;

    // Scaled window product: period times tolerance code.
    always_comb begin
        prod = {{CW{1'b0}}, sym_period} * {{PER_W{1'b0}}, tol_code};
    end

    // Track the inputs while disabled, hold while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q  <= '0;
            need_q <= '0;
        end else if (!en) begin
            win_q  <= PER_W'(prod >> sec_pkg::FRAC_SH);
            need_q <= sec_pkg::need_of(size_code);
        end
    end
endmodule

// File: rtl/sec_track.sv
// Edge matcher: pairs expected-edge strobes with detected-edge strobes inside
// a window of +/- win cycles and emits one-cycle pass and fail indications.
// An edge seen before its strobe is held as pending; a strobe seen before its
// edge opens a late window. Assumes strobes are spaced more than 2*win apart.
module sec_track #(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [PER_W-1:0] win,
    input  logic             exp_stb,
    input  logic             edge_stb,
    output logic             pass_p,
    output logic             fail_p
);
    localparam logic [PER_W-1:0] ONE = PER_W'(1);

    logic             late_open, pend;
    logic [PER_W-1:0] late_rem, pend_rem;
    logic             n_late_open, n_pend;
    logic [PER_W-1:0] n_late_rem, n_pend_rem;
    logic             pass_c, fail_c, s_used, e_used;

    // Verdict and next state for this cycle's strobes.
    always_comb begin
        pass_c = 1'b0;  fail_c = 1'b0;
        s_used = 1'b0;  e_used = 1'b0;
        n_late_open = late_open;  n_late_rem = late_rem;
        n_pend      = pend;       n_pend_rem = pend_rem;
        if (late_open) begin
            if (exp_stb) begin
                fail_c = 1'b1;  n_late_open = 1'b0;
            end else if (edge_stb) begin
                pass_c = 1'b1;  n_late_open = 1'b0;  e_used = 1'b1;
            end else if (late_rem == ONE) begin
                fail_c = 1'b1;  n_late_open = 1'b0;
            end else begin
                n_late_rem = late_rem - ONE;
            end
        end
        if (pend) begin
            if (exp_stb) begin
                pass_c = 1'b1;  n_pend = 1'b0;  s_used = 1'b1;
            end else if (pend_rem == ONE) begin
                fail_c = 1'b1;  n_pend = 1'b0;
            end else begin
                n_pend_rem = pend_rem - ONE;
            end
        end
        if (exp_stb && !s_used) begin
            if (edge_stb) begin
                pass_c = 1'b1;  e_used = 1'b1;
            end else if (win == '0) begin
                fail_c = 1'b1;
            end else begin
                n_late_open = 1'b1;  n_late_rem = win;
            end
        end
        if (edge_stb && !e_used) begin
            if (win == '0) begin
                fail_c = 1'b1;
            end else begin
                if (n_pend) fail_c = 1'b1;
                n_pend = 1'b1;  n_pend_rem = win;
            end
        end
    end

    // Matching state, cleared whenever the check is inactive.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            late_open <= 1'b0;  late_rem <= '0;
            pend      <= 1'b0;  pend_rem <= '0;
        end else begin
            late_open <= n_late_open;  late_rem <= n_late_rem;
            pend      <= n_pend;       pend_rem <= n_pend_rem;
        end
    end

    assign pass_p = active && pass_c;
    assign fail_p = active && fail_c;
endmodule

// File: rtl/sec_score.sv
// Run scorer: counts consecutive passing symbols up to the required count,
// raises the OK flag on reaching it and pulses the error flag on a failure.
// A failure in the same cycle as a pass wins.
module sec_score #(
    parameter int NEED_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic [NEED_W-1:0] need,
    input  logic              pass_p,
    input  logic              fail_p,
    output logic [NEED_W-1:0] cnt,
    output logic              timing_ok,
    output logic              timing_err
);
    logic [NEED_W:0] cnt_inc;

    // Next run length, one bit wider so the compare cannot wrap.
    always_comb begin
        cnt_inc = {1'b0, cnt} + (NEED_W + 1)'(1);
    end

    // Run counter and output flags.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            cnt        <= '0;
            timing_ok  <= 1'b0;
            timing_err <= 1'b0;
        end else if (fail_p) begin
            cnt        <= '0;
            timing_ok  <= 1'b0;
            timing_err <= 1'b1;
        end else begin
            timing_err <= 1'b0;
            if (pass_p) begin
                if (cnt != need) cnt <= cnt_inc[NEED_W-1:0];
                if (cnt_inc >= {1'b0, need}) timing_ok <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sym_edge_chk.sv
// Symbol edge timing checker for one receive path. Captures configuration
// while disabled, matches detected edges against expected positions from the
// clock recovery logic, and scores consecutive on-time symbols.
// Assumes one expected-edge strobe per symbol period.
module sym_edge_chk #(
    parameter int PER_W = 8,
    localparam int CW     = sec_pkg::CODE_W,
    localparam int NEED_W = CW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CW-1:0]    tol_code,
    input  logic [CW-1:0]    size_code,
    input  logic [PER_W-1:0] sym_period,
    input  logic             exp_stb,
    input  logic             edge_stb,
    output logic             timing_ok,
    output logic             timing_err
);
    logic [PER_W-1:0]  win_q;
    logic [NEED_W-1:0] need_q;
    logic [NEED_W-1:0] cnt;
    logic              active, pass_p, fail_p;

    // Check runs only while enabled with a non-zero run length.
    assign active = en && (need_q != '0);

    sec_cfg #(.PER_W(PER_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .en(en),
        .tol_code(tol_code), .size_code(size_code), .sym_period(sym_period),
        .win_q(win_q), .need_q(need_q)
    );

    sec_track #(.PER_W(PER_W)) u_track (
        .clk(clk), .rst_n(rst_n), .active(active), .win(win_q),
        .exp_stb(exp_stb), .edge_stb(edge_stb),
        .pass_p(pass_p), .fail_p(fail_p)
    );

    sec_score #(.NEED_W(NEED_W)) u_score (
        .clk(clk), .rst_n(rst_n), .active(active), .need(need_q),
        .pass_p(pass_p), .fail_p(fail_p), .cnt(cnt),
        .timing_ok(timing_ok), .timing_err(timing_err)
    );
endmodule

// File: rtl/sym_edge_chk_sva.sv
// Property checker for sym_edge_chk, attached by bind below.
module sym_edge_chk_sva #(
    parameter int PER_W  = 8,
    parameter int NEED_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              timing_ok,
    input logic              timing_err,
    input logic [PER_W-1:0]  win_q,
    input logic [NEED_W-1:0] need_q,
    input logic [NEED_W-1:0] cnt,
    input logic              pass_p
);
    p_cfg_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> ($stable(win_q) && $stable(need_q)));

    p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!timing_ok && !timing_err));

    p_size_off_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (need_q == '0) |=> (!timing_ok && !timing_err));

    p_err_clears_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
        timing_err |-> !timing_ok);

    p_ok_after_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timing_ok) |-> $past(pass_p));

    p_ok_full_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        timing_ok |-> (cnt == need_q));

    p_run_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= need_q);
endmodule

bind sym_edge_chk sym_edge_chk_sva #(.PER_W(PER_W), .NEED_W(NEED_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .en(en),
    .timing_ok(timing_ok), .timing_err(timing_err),
    .win_q(win_q), .need_q(need_q), .cnt(cnt), .pass_p(pass_p)
);

// File: tb/sym_edge_chk_tb.sv
module sym_edge_chk_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b1;
    logic [3:0] tol_code = 4'd8;
    logic [3:0] size_code = 4'd2;
    logic [7:0] sym_period = 8'd16;
    logic       exp_stb = 1'b0;
    logic       edge_stb = 1'b0;
    logic       timing_ok, timing_err;

    int  n_chk = 0;
    int  n_fail = 0;
    int  err_cnt = 0;
    bit  done = 1'b0;

    sym_edge_chk u_dut (
        .clk(clk), .rst_n(rst_n), .en(en),
        .tol_code(tol_code), .size_code(size_code), .sym_period(sym_period),
        .exp_stb(exp_stb), .edge_stb(edge_stb),
        .timing_ok(timing_ok), .timing_err(timing_err)
    );

    always #10ns clk = ~clk;

    // Vector: {tol, size, period, signed edge offset, symbol count}
    localparam int NV = 16;
    localparam logic [31:0] VECS [NV] = '{
        {4'd8,  4'd2,  8'd16, 8'h00, 8'd3},
        {4'd8,  4'd2,  8'd16, 8'h04, 8'd3},
        {4'd8,  4'd2,  8'd16, 8'hFC, 8'd3},
        {4'd8,  4'd2,  8'd16, 8'h05, 8'd3},
        {4'd8,  4'd2,  8'd16, 8'hFB, 8'd3},
        {4'd0,  4'd1,  8'd16, 8'h00, 8'd1},
        {4'd0,  4'd1,  8'd16, 8'h01, 8'd1},
        {4'd15, 4'd3,  8'd32, 8'h0F, 8'd5},
        {4'd15, 4'd3,  8'd32, 8'hF0, 8'd5},
        {4'd8,  4'd0,  8'd16, 8'h06, 8'd3},
        {4'd8,  4'd3,  8'd16, 8'h00, 8'd4},
        {4'd8,  4'd15, 8'd16, 8'h02, 8'd29},
        {4'd11, 4'd2,  8'd32, 8'hF5, 8'd3},
        {4'd11, 4'd2,  8'd32, 8'h0C, 8'd3},
        {4'd4,  4'd1,  8'd20, 8'h02, 8'd2},
        {4'd4,  4'd1,  8'd20, 8'h03, 8'd2}
    };

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    function automatic bit hit(input int t, input int s0, input int per, input int n);
        if (t < s0) return 1'b0;
        return ((t - s0) % per == 0) && ((t - s0) / per < n);
    endfunction

    // Drive n symbols; edges sit 'off' cycles from each expected strobe.
    task automatic drive_syms(input int per, input int off, input int n,
                              input bit do_stb, input bit do_edge);
        int total;
        total = per + n * per + per + 2;
        for (int t = 0; t < total; t++) begin
            @(negedge clk);
            if (timing_err) err_cnt++;
            exp_stb  = do_stb && hit(t, per, per, n);
            edge_stb = do_edge && hit(t - off, per, per, n);
        end
        @(negedge clk);
        if (timing_err) err_cnt++;
        exp_stb = 1'b0;
        edge_stb = 1'b0;
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            if (timing_err) err_cnt++;
        end
    endtask

    task automatic configure(input int tol, input int sz, input int per);
        @(negedge clk);
        en = 1'b0;
        tol_code = 4'(tol);
        size_code = 4'(sz);
        sym_period = 8'(per);
        @(negedge clk);
        @(negedge clk);
        en = 1'b1;
        err_cnt = 0;
    endtask

    initial begin
        // R8: reset holds outputs low even with the path enabled
        for (int k = 0; k < 3; k++) @(negedge clk);
        chk("R8", "ok in reset", int'(timing_ok), 0);
        chk("R8", "err in reset", int'(timing_err), 0);
        rst_n = 1'b1;
        en = 1'b0;
        @(negedge clk);
        chk("R8", "ok after reset", int'(timing_ok), 0);

        // Table walk: R1 window, R2 zero tolerance, R3 run length, R4 off
        for (int v = 0; v < NV; v++) begin
            int tol, sz, per, off, n, w, a, need, e_ok, e_err;
            string tag;
            tol = int'(VECS[v][31:28]);
            sz  = int'(VECS[v][27:24]);
            per = int'(VECS[v][23:16]);
            off = int'($signed(VECS[v][15:8]));
            n   = int'(VECS[v][7:0]);
            w   = (per * tol) / 32;
            a   = (off < 0) ? -off : off;
            need = 2 * sz - 1;
            if (sz == 0) begin
                e_ok = 0; e_err = 0; tag = "R4";
            end else if (a <= w) begin
                e_ok = (n >= need) ? 1 : 0; e_err = 0;
                tag = (tol == 0) ? "R2" : ((n < need || sz == 15) ? "R3" : "R1");
            end else begin
                e_ok = 0; e_err = 1;
                tag = (tol == 0) ? "R2" : "R1";
            end
            configure(tol, sz, per);
            drive_syms(per, off, n, 1'b1, 1'b1);
            chk(tag, $sformatf("vec %0d ok", v), int'(timing_ok), e_ok);
            chk(tag, $sformatf("vec %0d err seen", v), (err_cnt > 0) ? 1 : 0, e_err);
        end

        // R6: changes while enabled are ignored
        configure(8, 2, 16);
        tol_code = 4'd0;
        size_code = 4'd0;
        sym_period = 8'd100;
        drive_syms(16, 3, 3, 1'b1, 1'b1);
        chk("R6", "ok with frozen cfg", int'(timing_ok), 1);
        chk("R6", "errs with frozen cfg", err_cnt, 0);

        // R9: further passes keep OK high
        err_cnt = 0;
        drive_syms(16, -2, 4, 1'b1, 1'b1);
        chk("R9", "ok after extra passes", int'(timing_ok), 1);
        chk("R9", "errs after extra passes", err_cnt, 0);

        // R5: missing edge gives one error pulse and drops OK
        err_cnt = 0;
        drive_syms(16, 0, 1, 1'b1, 1'b0);
        chk("R5", "missing edge pulses", err_cnt, 1);
        chk("R5", "ok after missing edge", int'(timing_ok), 0);

        // R5: stray edge with no expected position
        err_cnt = 0;
        drive_syms(16, 0, 1, 1'b0, 1'b1);
        chk("R5", "stray edge pulses", err_cnt, 1);

        // R3: regain OK, then R7: disable clears it and the run
        err_cnt = 0;
        drive_syms(16, 0, 3, 1'b1, 1'b1);
        chk("R3", "ok regained", int'(timing_ok), 1);
        @(negedge clk);
        en = 1'b0;
        tol_code = 4'd8;
        size_code = 4'd2;
        sym_period = 8'd16;
        @(negedge clk);
        chk("R7", "ok after disable", int'(timing_ok), 0);
        chk("R7", "err after disable", int'(timing_err), 0);
        en = 1'b1;
        err_cnt = 0;
        drive_syms(16, 0, 2, 1'b1, 1'b1);
        chk("R7", "ok short of new run", int'(timing_ok), 0);
        drive_syms(16, 0, 1, 1'b1, 1'b1);
        chk("R7", "ok after new run", int'(timing_ok), 1);
        chk("R7", "errs after re-enable", err_cnt, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2ms;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule